// File: doc/BRIEF.md
# Instruction Fetch Exception Prioritizer

This block builds one instruction out of 16-bit fetch parcels and decides what the fetch stage hands on. Each parcel arrives on a valid/ready input together with a flag that marks a page fault seen while fetching it. The block looks at the low bits of the first parcel to find the instruction length. It takes a second parcel when the instruction is 32 bits wide. It then issues a single result with a 2-bit cause code: a good 16-bit instruction, a good 32-bit instruction, an instruction page fault, or an illegal instruction.

The ordering matters. Once the block knows that the length is one it handles, it collects every parcel of the instruction, even when the bits it has already seen prove the encoding illegal. A fault on any of those parcels then outranks the illegal finding. The one case where the block gives up early is a first parcel whose length is not supported at all, which happens when the compressed extension is switched off. A flush input drops a half-built instruction and any result that is still waiting. A parameter decides whether a compressed stack-relative word load that writes register 0 counts as reserved.

Top module: `ifx_prio`

## Requirements
- R1: After reset, res_valid is 0 and in_ready is 1.
- R2: With the compressed extension enabled, a parcel whose bits [1:0] are not 11 completes a 16-bit instruction. The result is valid on the clock edge that accepts the parcel, with res_wide=0, res_insn equal to the parcel zero-extended, and cause 00 when no check fails.
- R3: A first parcel whose bits [1:0] are 11 produces no result. The next accepted parcel is placed in res_insn[31:16], the first parcel is in res_insn[15:0], and res_wide=1.
- R4: If either parcel of an instruction carried in_fault=1, the cause is 01 (page fault), even when the encoding is also illegal.
- R5: A 16-bit parcel of all zeros gives cause 10 (illegal) when no fault is present.
- R6: A 32-bit instruction whose bits [4:2] are 111 asks for a length above 32 bits and gives cause 10. This includes all ones. The block judges it only after taking the second parcel, so a first parcel of 16'hFFFF alone produces no result.
- R7: With LWSP_X0_RESERVED=1, a 16-bit parcel with bits [1:0]=10, bits [15:13]=010 and bits [11:7]=0 gives cause 10. The same parcel with bits [11:7] non-zero gives cause 00.
- R8: With COMPRESSED_EN=0, a first parcel whose bits [1:0] are not 11 gives cause 10 (or 01 if that parcel faulted) at once, with res_wide=0, and no second parcel is taken.
- R9: A valid result keeps res_valid, res_cause, res_wide and res_insn steady until a cycle with res_ready=1. During that time in_ready is 0, so no parcel is taken.
- R10: Asserting flush clears a pending result and any half-built instruction. A parcel offered while flush is high is not taken.
- R11: The cause code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Drop partial instruction and pending result |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Block takes the parcel this cycle |
| in_parcel | input | 16 | Fetch parcel |
| in_fault | input | 1 | Page fault seen on this parcel |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_cause | output | 2 | 00 ok, 01 page fault, 10 illegal |
| res_wide | output | 1 | 1 for a 32-bit instruction |
| res_insn | output | 32 | Assembled instruction bits |

## Verification
A result becomes visible one register stage after the edge that accepts the parcel completing the instruction. That is the first parcel for a 16-bit or unsupported-length case, and the second parcel for a 32-bit one. The bench drives each parcel on a falling edge, removes it on the next falling edge, and reads the outputs right then. After a first parcel with low bits 11, it checks at that same point that no result has appeared yet. Results are cleared one edge after res_ready is held high, and hold and flush tests read the outputs on every falling edge in between.

// File: rtl/ifx_pkg.sv
// Shared widths, cause codes and result record for the fetch prioritizer.
// Assumes 16-bit fetch parcels and a longest supported instruction of 32 bits.
package ifx_pkg;
    localparam int PARCEL_W = 16;
    localparam int INSN_W   = 2 * PARCEL_W;

    typedef enum logic [1:0] {
        CAUSE_OK  = 2'b00,
        CAUSE_PF  = 2'b01,
        CAUSE_ILL = 2'b10
    } cause_e;

    typedef struct packed {
        logic                wide;
        cause_e              cause;
        logic [INSN_W-1:0]   insn;
    } result_t;
endpackage

// File: rtl/ifx_len_decode.sv
// Length decode of a first parcel: says whether an upper parcel must follow
// and whether a single-parcel length is supported in this configuration.
// Assumes the standard rule that low bits 11 mark an instruction wider than 16.
module ifx_len_decode #(
    parameter bit COMPRESSED_EN = 1'b1
) (
    input  logic [ifx_pkg::PARCEL_W-1:0] parcel,
    output logic                         need_upper,
    output logic                         short_ok
);
    // Low two bits 11 mean at least one more parcel follows.
    always_comb need_upper = (parcel[1:0] == 2'b11);

    generate
        if (COMPRESSED_EN) begin : g_short_on
            // 16-bit length is a supported size.
            always_comb short_ok = (parcel[1:0] != 2'b11);
        end else begin : g_short_off
            // Without compressed support no single-parcel length is valid.
            always_comb short_ok = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ifx_legal_check.sv
// Encoding legality on a fully gathered instruction of supported length.
// Assumes the caller has already rejected unsupported 16-bit lengths.
module ifx_legal_check #(
    parameter bit LWSP_X0_RESERVED = 1'b1
) (
    input  logic [ifx_pkg::INSN_W-1:0] insn,
    input  logic                       wide,
    output logic                       illegal
);
    logic zero_short;
    logic lwsp_x0;
    logic over_long;

    // A 16-bit parcel of all zeros is the defined illegal pattern.
    always_comb zero_short = (insn[15:0] == 16'h0000);

    // Lengths above 32 bits are signalled by bits [4:2] all set.
    always_comb over_long = (insn[4:2] == 3'b111);

    generate
        if (LWSP_X0_RESERVED) begin : g_lwsp_rsvd
            // Stack-relative word load into register 0 is reserved.
            always_comb lwsp_x0 = (insn[1:0] == 2'b10) && (insn[15:13] == 3'b010)
                                  && (insn[11:7] == 5'd0);
        end else begin : g_lwsp_legal
            // The same encoding is accepted as an ordinary load.
            always_comb lwsp_x0 = 1'b0;
        end
    endgenerate

    // Pick the rule set that matches the gathered width.
    always_comb illegal = wide ? over_long : (zero_short | lwsp_x0);
endmodule

// File: rtl/ifx_prio.sv
// Fetch exception prioritizer: gathers one instruction from 16-bit parcels,
// never exits early once the length is supported, and ranks a page fault on
// any parcel above an illegal encoding. Holds the result until res_ready.
// Assumes a synchronous active-low reset and that flush wins over all input.
module ifx_prio #(
    parameter bit COMPRESSED_EN    = 1'b1,
    parameter bit LWSP_X0_RESERVED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_parcel,
    input  logic        in_fault,
    output logic        res_valid,
    input  logic        res_ready,
    output logic [1:0]  res_cause,
    output logic        res_wide,
    output logic [31:0] res_insn
);
    import ifx_pkg::*;

    typedef enum logic {S_FIRST = 1'b0, S_UPPER = 1'b1} state_e;

    state_e                state_q;
    logic [PARCEL_W-1:0]   lo_q;
    logic                  lo_flt_q;
    logic                  valid_q;
    result_t               res_q;

    logic                  accept;
    logic                  need_upper;
    logic                  short_ok;
    logic                  cand_wide;
    logic [INSN_W-1:0]     cand_insn;
    logic                  cand_fault;
    logic                  enc_illegal;
    logic                  cand_illegal;
    logic                  finish;
    cause_e                cand_cause;

    ifx_len_decode #(.COMPRESSED_EN(COMPRESSED_EN)) u_len (
        .parcel     (in_parcel),
        .need_upper (need_upper),
        .short_ok   (short_ok)
    );

    ifx_legal_check #(.LWSP_X0_RESERVED(LWSP_X0_RESERVED)) u_legal (
        .insn    (cand_insn),
        .wide    (cand_wide),
        .illegal (enc_illegal)
    );

    // Parcels are taken only with no result waiting and no flush.
    always_comb in_ready = ~valid_q & ~flush;
    always_comb accept   = in_valid & in_ready;

    // Form the candidate instruction and its combined fault flag.
    always_comb begin
        cand_wide  = (state_q == S_UPPER);
        cand_insn  = cand_wide ? {in_parcel, lo_q} : {{PARCEL_W{1'b0}}, in_parcel};
        cand_fault = in_fault | (cand_wide & lo_flt_q);
    end

    // An unsupported short length is illegal regardless of encoding rules.
    always_comb cand_illegal = enc_illegal | (~cand_wide & ~short_ok);

    // The instruction completes on the upper parcel or on a short first one.
    always_comb finish = accept & (cand_wide | ~need_upper);

    // Fault outranks illegal, illegal outranks ok.
    always_comb begin
        if (cand_fault)        cand_cause = CAUSE_PF;
        else if (cand_illegal) cand_cause = CAUSE_ILL;
        else                   cand_cause = CAUSE_OK;
    end

    // Assembly state, saved lower parcel and held result.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state_q  <= S_FIRST;
            lo_q     <= '0;
            lo_flt_q <= 1'b0;
            valid_q  <= 1'b0;
            res_q    <= '0;
        end else begin
            if (valid_q && res_ready) valid_q <= 1'b0;
            if (finish) begin
                valid_q     <= 1'b1;
                res_q.wide  <= cand_wide;
                res_q.cause <= cand_cause;
                res_q.insn  <= cand_insn;
                state_q     <= S_FIRST;
            end else if (accept) begin
                lo_q     <= in_parcel;
                lo_flt_q <= in_fault;
                state_q  <= S_UPPER;
            end
        end
    end

    // Drive the result ports from the held record.
    always_comb begin
        res_valid = valid_q;
        res_cause = res_q.cause;
        res_wide  = res_q.wide;
        res_insn  = res_q.insn;
    end
endmodule

// File: rtl/ifx_prio_chk.sv
// Port-level checker for the prioritizer. Keeps its own record of whether an
// upper parcel is due, built from the input handshake alone.
module ifx_prio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_parcel,
    input logic        in_fault,
    input logic        res_valid,
    input logic        res_ready,
    input logic [1:0]  res_cause
);
    logic acc;
    logic mid_q;
    logic flt_q;

    // Handshake seen at the input.
    always_comb acc = in_valid & in_ready;

    // Track a pending upper parcel and its lower-parcel fault.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mid_q <= 1'b0;
            flt_q <= 1'b0;
        end else if (acc) begin
            mid_q <= ~mid_q & (in_parcel[1:0] == 2'b11);
            flt_q <= in_fault;
        end
    end

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready && !flush |=> res_valid && $stable(res_cause));

    // R9
    busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !res_valid);

    // R4
    fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (in_fault || (mid_q && flt_q)) && (mid_q || in_parcel[1:0] != 2'b11)
        |=> res_valid && res_cause == 2'b01);

    // R5
    zero_parcel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !mid_q && in_parcel == 16'h0000 && !in_fault
        |=> res_valid && res_cause == 2'b10);

    // R3
    upper_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !mid_q && in_parcel[1:0] == 2'b11 |=> !res_valid);

    // R11
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_cause != 2'b11);
endmodule

bind ifx_prio ifx_prio_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_parcel (in_parcel),
    .in_fault  (in_fault),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_cause (res_cause)
);

// File: tb/tb_ifx_prio.sv
module tb_ifx_prio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_parcel = '0;
    logic        in_fault = 1'b0;
    logic        res_ready = 1'b0;

    logic        in_ready,  res_valid,  res_wide;
    logic [1:0]  res_cause;
    logic [31:0] res_insn;
    logic        nc_ready,  nc_valid,   nc_wide;
    logic [1:0]  nc_cause;
    logic [31:0] nc_insn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ifx_prio dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_parcel(in_parcel), .in_fault(in_fault),
        .res_valid(res_valid), .res_ready(res_ready), .res_cause(res_cause),
        .res_wide(res_wide), .res_insn(res_insn)
    );

    ifx_prio #(.COMPRESSED_EN(1'b0)) dut_nc (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(nc_ready), .in_parcel(in_parcel), .in_fault(in_fault),
        .res_valid(nc_valid), .res_ready(res_ready), .res_cause(nc_cause),
        .res_wide(nc_wide), .res_insn(nc_insn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] p, input logic f);
        @(negedge clk);
        in_valid = 1'b1; in_parcel = p; in_fault = f;
        @(negedge clk);
        in_valid = 1'b0; in_fault = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk); res_ready = 1'b1;
        @(negedge clk); res_ready = 1'b0;
    endtask

    task automatic expect_main(input string req, input logic w, input logic [1:0] c, input logic [31:0] i);
        chk(req, {63'd0, res_valid}, 64'd1);
        chk(req, {61'd0, w, c}, {61'd0, res_wide, res_cause});
        chk(req, {32'd0, res_insn}, {32'd0, i});
    endtask

    task automatic expect_nc(input string req, input logic w, input logic [1:0] c, input logic [31:0] i);
        chk(req, {63'd0, nc_valid}, 64'd1);
        chk(req, {61'd0, w, c}, {61'd0, nc_wide, nc_cause});
        chk(req, {32'd0, nc_insn}, {32'd0, i});
    endtask

    task automatic t_reset();
        chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
        chk("R1 in_ready",  {63'd0, in_ready},  64'd1);
    endtask

    task automatic t_short();
        put(16'h4501, 1'b0);
        expect_main("R2 short ok", 1'b0, 2'b00, 32'h0000_4501);
        expect_nc("R8 short unsupported", 1'b0, 2'b10, 32'h0000_4501);
        drain();
        put(16'h4501, 1'b1);
        expect_nc("R8 short fault", 1'b0, 2'b01, 32'h0000_4501);
        expect_main("R4 short fault", 1'b0, 2'b01, 32'h0000_4501);
        drain();
    endtask

    task automatic t_wide();
        put(16'h0513, 1'b0);
        chk("R3 no result after lower", {63'd0, res_valid}, 64'd0);
        put(16'h0000, 1'b0);
        expect_main("R3 wide ok", 1'b1, 2'b00, 32'h0000_0513);
        expect_nc("R8 wide ok", 1'b1, 2'b00, 32'h0000_0513);
        drain();
    endtask

    task automatic t_zero();
        put(16'h0000, 1'b0);
        expect_main("R5 zero parcel", 1'b0, 2'b10, 32'h0);
        drain();
        put(16'h0000, 1'b1);
        expect_main("R4 zero parcel fault", 1'b0, 2'b01, 32'h0);
        drain();
    endtask

    task automatic t_ones();
        put(16'hFFFF, 1'b0);
        chk("R6 sixteen ones alone", {63'd0, res_valid}, 64'd0);
        put(16'hFFFF, 1'b0);
        expect_main("R6 all ones", 1'b1, 2'b10, 32'hFFFF_FFFF);
        drain();
        put(16'h001F, 1'b0);
        put(16'h0000, 1'b0);
        expect_main("R6 long prefix", 1'b1, 2'b10, 32'h0000_001F);
        drain();
    endtask

    task automatic t_fault_late();
        put(16'hFFFF, 1'b0);
        put(16'hFFFF, 1'b1);
        expect_main("R4 upper fault over illegal", 1'b1, 2'b01, 32'hFFFF_FFFF);
        drain();
        put(16'hFFFF, 1'b1);
        chk("R4 keeps gathering", {63'd0, res_valid}, 64'd0);
        put(16'hFFFF, 1'b0);
        expect_main("R4 lower fault", 1'b1, 2'b01, 32'hFFFF_FFFF);
        drain();
    endtask

    task automatic t_lwsp();
        put(16'h4002, 1'b0);
        expect_main("R7 load to x0", 1'b0, 2'b10, 32'h0000_4002);
        drain();
        put(16'h4082, 1'b0);
        expect_main("R7 load to x1", 1'b0, 2'b00, 32'h0000_4082);
        drain();
    endtask

    task automatic t_hold();
        put(16'h0001, 1'b0);
        in_valid = 1'b1; in_parcel = 16'h0003;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            expect_main("R9 held", 1'b0, 2'b00, 32'h0000_0001);
            chk("R9 not ready", {63'd0, in_ready}, 64'd0);
        end
        res_ready = 1'b1; in_valid = 1'b0;
        @(negedge clk); res_ready = 1'b0;
        chk("R9 released", {63'd0, res_valid}, 64'd0);
        put(16'h0005, 1'b0);
        expect_main("R9 offered parcel ignored", 1'b0, 2'b00, 32'h0000_0005);
        drain();
    endtask

    task automatic t_flush();
        put(16'h0013, 1'b0);
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_parcel = 16'h0000;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        chk("R10 no result", {63'd0, res_valid}, 64'd0);
        put(16'h0009, 1'b0);
        expect_main("R10 partial dropped", 1'b0, 2'b00, 32'h0000_0009);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        chk("R10 pending dropped", {63'd0, res_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_wide();
        t_zero();
        t_ones();
        t_fault_late();
        t_lwsp();
        t_hold();
        t_flush();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule